// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Unit

This block holds two identical countdown timers and a shared interrupt unit behind one 32-bit register interface. Each timer stores a reload value (divisor) and keeps a live down-counter. A control word sets what the timer does and which tick strobe makes it count. Clocks are not generated here. Four rate strobes, one external strobe and a time strobe arrive as single-cycle enables from elsewhere in the chip.

When a running timer reaches the end of its period, it raises its own status bit. A mask register selects which status bits can drive the single level interrupt. Software clears status bits by writing ones to an acknowledge address. That acknowledge acts for one cycle only and always reads back as zero. A free-running time counter advances on its own strobe and is read-only.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Register offsets: timer n (n = 0 or 1) has its divisor at 0x00 + 0x10·n, its count at 0x04 + 0x10·n and its control at 0x08 + 0x10·n. The time counter is at 0x38, mask at 0x48, acknowledge at 0x4C, raw status at 0x50 and masked status at 0x54.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset, the following all read zero and `irq` is low: both counts, both divisors, both controls, mask, raw status, masked status and the time counter.
- R2: Control bits [1:0] hold the operation code and bits [4:2] hold the source code; the control register reads back its 5 stored bits. Writing op 0 (load) copies the divisor into the count and stops the timer. Writing a divisor only stores it and leaves the count unchanged.
- R3: Writing op 2 (run) starts counting. Source codes 4 to 7 select `rate_tick[0]` to `rate_tick[3]`, and source code 1 selects `ext_tick`. Strobes that are not selected have no effect on the count.
- R4: A running timer with count above 1 decrements by one on each selected strobe. With count 1 or 0, a selected strobe expires the timer and reloads the count from the divisor. A divisor of N therefore gives one expiry every N strobes.
- R5: An expiry of timer 0 sets raw status bit 0 on the next edge, and an expiry of timer 1 sets bit 1. If an expiry and an acknowledge of the same bit fall in one cycle, the bit is set.
- R6: Masked status reads raw AND mask. `irq` is high exactly when masked status is nonzero, and it follows mask writes in the same cycle that the mask register changes.
- R7: Writing the acknowledge address clears exactly the raw status bits written as 1. Other bits are untouched, and the acknowledge address always reads zero.
- R8: Writing op 1 (hold) stops the timer, and the count stays constant under any strobe.
- R9: Writing op 3 stops the timer as hold does. Source code 0 (disabled) and the undefined source codes 2 and 3 never decrement the count.
- R10: The time counter increments by one on each `time_tick`, and writes to its address are ignored.
- R11: Reads of unmapped addresses return zero. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| rate_tick | input | 4 | Rate tick enables for source codes 4 to 7 |
| ext_tick | input | 1 | External tick enable for source code 1 |
| time_tick | input | 1 | Increment enable for the time counter |
| irq | output | 1 | Level interrupt, high while masked status is nonzero |

## Verification
The count register can be read at any time, so a wrong reload, a missed decrement or a wrong source decode shows up at the first read after the strobe that caused it. A status bit that is set or cleared wrongly shows up in the raw and masked views one cycle after the expiry or acknowledge. If the mask bit is open, it also shows on `irq` in that same cycle. A running flag that is stuck on or off shows up as a count that moves during hold, or that stays put during run, after a single selected strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DW      = 32;
    localparam int AW      = 8;
    localparam int OP_W    = 2;
    localparam int SRC_W   = 3;
    localparam int N_RATES = 4;
    localparam int CTRL_W  = OP_W + SRC_W;

    // Per-timer offsets, replicated at a fixed stride
    localparam int OFS_DIV    = 'h00;
    localparam int OFS_CNT    = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int TMR_STRIDE = 'h10;

    // Shared registers
    localparam int OFS_TIME = 'h38;
    localparam int OFS_MASK = 'h48;
    localparam int OFS_ACK  = 'h4C;
    localparam int OFS_RAW  = 'h50;
    localparam int OFS_MSKD = 'h54;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        tmr_op_e          op;
    } tmr_ctrl_t;

    // Source codes 0 (disabled), 1 (external) and 4..7 (rates) are defined
    function automatic logic src_legal(input logic [SRC_W-1:0] s);
        return s[2] || (s == 3'd0) || (s == 3'd1);
    endfunction

    function automatic logic src_tick(input logic [SRC_W-1:0] s,
                                      input logic [N_RATES-1:0] rates,
                                      input logic ext);
        logic t;
        t = 1'b0;
        if (s[2])
            t = rates[s[1:0]];
        else if (s == 3'd1)
            t = ext;
        return t;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               div_we,
    input  logic [W-1:0]       div_wdata,
    input  logic               ctrl_we,
    input  tmr_ctrl_t          ctrl_wdata,
    input  logic [N_RATES-1:0] rate_tick,
    input  logic               ext_tick,
    output logic [W-1:0]       div_q,
    output tmr_ctrl_t          ctrl_q,
    output logic [W-1:0]       cnt_q,
    output logic               expire
);

    logic running_q;
    logic sel_tick;
    logic at_end;

    assign sel_tick = src_tick(ctrl_q.src, rate_tick, ext_tick);
    assign at_end   = (cnt_q <= W'(1));
    // A control write in the same cycle takes priority over a strobe
    assign expire   = running_q && sel_tick && !ctrl_we && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            ctrl_q    <= '{src: '0, op: OP_LOAD};
            cnt_q     <= '0;
            running_q <= 1'b0;
        end else begin
            if (div_we)
                div_q <= div_wdata;

            if (ctrl_we) begin
                ctrl_q <= ctrl_wdata;
                unique case (ctrl_wdata.op)
                    OP_LOAD: begin
                        cnt_q     <= div_q;
                        running_q <= 1'b0;
                    end
                    OP_RUN:  running_q <= src_legal(ctrl_wdata.src);
                    default: running_q <= 1'b0;
                endcase
            end else if (running_q && sel_tick) begin
                if (at_end)
                    cnt_q <= div_q;
                else
                    cnt_q <= cnt_q - W'(1);
            end
        end
    end

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] expire,
    input  logic         mask_we,
    input  logic         ack_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] masked,
    output logic         irq
);

    logic [N-1:0] ack_pulse;

    // The acknowledge exists only for the write cycle; nothing is stored
    assign ack_pulse = ack_we ? wdata : '0;
    assign masked    = raw_q & mask_q;
    assign irq       = |masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~ack_pulse) | expire;
            if (mask_we)
                mask_q <= wdata;
        end
    end

endmodule

// File: rtl/tmr_free_time.sv
module tmr_free_time #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] time_q
);

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else if (tick)
            time_q <= time_q + W'(1);
    end

endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int DATA_W  = DW,
    parameter int ADDR_W  = AW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_RATES-1:0]  rate_tick,
    input  logic                ext_tick,
    input  logic                time_tick,
    output logic                irq
);

    localparam int PAD_CTRL = DATA_W - CTRL_W;
    localparam int PAD_IRQ  = DATA_W - NUM_TMR;

    logic [NUM_TMR-1:0][DATA_W-1:0] div_q;
    logic [NUM_TMR-1:0][DATA_W-1:0] cnt_q;
    tmr_ctrl_t [NUM_TMR-1:0]        ctrl_q;
    logic [NUM_TMR-1:0]             expire;
    logic [NUM_TMR-1:0]             raw_q;
    logic [NUM_TMR-1:0]             mask_q;
    logic [NUM_TMR-1:0]             masked;
    logic [DATA_W-1:0]              time_q;

    logic mask_we;
    logic ack_we;

    assign mask_we = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    assign ack_we  = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(TMR_STRIDE * i + OFS_DIV);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(TMR_STRIDE * i + OFS_CTRL);

        tmr_channel #(.W(DATA_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .div_we     (bus_wr && (bus_addr == A_DIV)),
            .div_wdata  (bus_wdata),
            .ctrl_we    (bus_wr && (bus_addr == A_CTRL)),
            .ctrl_wdata (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
            .rate_tick  (rate_tick),
            .ext_tick   (ext_tick),
            .div_q      (div_q[i]),
            .ctrl_q     (ctrl_q[i]),
            .cnt_q      (cnt_q[i]),
            .expire     (expire[i])
        );
    end

    tmr_irq_unit #(.N(NUM_TMR)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wdata   (bus_wdata[NUM_TMR-1:0]),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .irq     (irq)
    );

    tmr_free_time #(.W(DATA_W)) u_time (
        .clk    (clk),
        .rst    (rst),
        .tick   (time_tick),
        .time_q (time_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_TIME): bus_rdata = time_q;
            ADDR_W'(OFS_MASK): bus_rdata = {{PAD_IRQ{1'b0}}, mask_q};
            ADDR_W'(OFS_RAW):  bus_rdata = {{PAD_IRQ{1'b0}}, raw_q};
            ADDR_W'(OFS_MSKD): bus_rdata = {{PAD_IRQ{1'b0}}, masked};
            default:           bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(TMR_STRIDE * i + OFS_DIV))
                bus_rdata = div_q[i];
            if (bus_addr == ADDR_W'(TMR_STRIDE * i + OFS_CNT))
                bus_rdata = cnt_q[i];
            if (bus_addr == ADDR_W'(TMR_STRIDE * i + OFS_CTRL))
                bus_rdata = {{PAD_CTRL{1'b0}}, ctrl_q[i]};
        end
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int DATA_W  = DW,
    parameter int ADDR_W  = AW
) (
    input logic                           clk,
    input logic                           rst,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_wr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic                           time_tick,
    input logic                           irq,
    input logic [NUM_TMR-1:0]             expire,
    input logic [NUM_TMR-1:0]             raw_q,
    input logic [NUM_TMR-1:0]             mask_q,
    input logic [NUM_TMR-1:0][DATA_W-1:0] div_q,
    input logic [NUM_TMR-1:0][DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0]              time_q
);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_c
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(TMR_STRIDE * i + OFS_CTRL);

        // R2
        load_copies_div_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_CTRL && bus_wdata[1:0] == 2'd0)
            |=> (cnt_q[i] == $past(div_q[i])));

        // R8
        hold_freezes_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_CTRL && bus_wdata[1:0] == 2'd1)
            |=> $stable(cnt_q[i]));

        // R5
        expiry_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> raw_q[i]);

        // R7
        ack_clears_raw_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(OFS_ACK) && bus_wdata[i] && !expire[i])
            |=> !raw_q[i]);
    end

    // R6
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    // R10
    time_step_chk: assert property (@(posedge clk) disable iff (rst)
        time_tick |=> (time_q == $past(time_q) + DATA_W'(1)));

endmodule

bind dual_timer_irq tmr_chk #(
    .NUM_TMR (NUM_TMR),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_tmr_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .time_tick (time_tick),
    .irq       (irq),
    .expire    (expire),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .div_q     (div_q),
    .cnt_q     (cnt_q),
    .time_q    (time_q)
);

// File: tb/tb_dual_timer_irq.sv
`timescale 1ns/1ps
module tb_dual_timer_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  rate_tick = '0;
    logic        ext_tick = 1'b0;
    logic        time_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #2.5 clk = ~clk;

    dual_timer_irq dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rate_tick (rate_tick),
        .ext_tick  (ext_tick),
        .time_tick (time_tick),
        .irq       (irq)
    );

    // Monitor: pops expectations and compares once the read data has settled
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sbq.pop_front();
                act = it.is_irq ? {31'd0, irq} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr  = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        sbq.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.is_irq = 1'b1;
        it.exp    = {31'd0, e};
        it.tag    = tag;
        sbq.push_back(it);
    endtask

    task automatic pulse_rate(input logic [3:0] m);
        @(negedge clk);
        rate_tick = m;
        @(negedge clk);
        rate_tick = '0;
    endtask

    task automatic pulse_ext();
        @(negedge clk);
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h04, 32'h0, "R1 cnt0");
        rd(8'h14, 32'h0, "R1 cnt1");
        rd(8'h00, 32'h0, "R1 div0");
        rd(8'h18, 32'h0, "R1 ctrl1");
        rd(8'h48, 32'h0, "R1 mask");
        rd(8'h50, 32'h0, "R1 raw");
        rd(8'h54, 32'h0, "R1 masked");
        rd(8'h38, 32'h0, "R1 time");
        chk_irq(1'b0, "R1 irq");

        // R2 load, readback
        wr(8'h00, 32'd3);
        rd(8'h04, 32'h0, "R2 div write leaves cnt");
        wr(8'h08, 32'h10);
        rd(8'h04, 32'd3, "R2 load copies div");
        rd(8'h08, 32'h10, "R2 ctrl readback");

        // R3 run with source 4 (rate_tick[0])
        wr(8'h08, 32'h12);
        pulse_rate(4'b0001);
        rd(8'h04, 32'd2, "R3 selected strobe decrements");
        pulse_rate(4'b1110);
        pulse_ext();
        rd(8'h04, 32'd2, "R3 unselected strobes ignored");

        // R4 expiry and reload, R5 status
        pulse_rate(4'b0001);
        rd(8'h04, 32'd1, "R4 decrement to 1");
        rd(8'h50, 32'h0, "R5 no status before expiry");
        pulse_rate(4'b0001);
        rd(8'h04, 32'd3, "R4 reload after expiry");
        rd(8'h50, 32'h1, "R5 timer0 sets bit0");
        rd(8'h54, 32'h0, "R6 masked zero with mask off");
        chk_irq(1'b0, "R6 irq low with mask off");

        // R6 mask
        wr(8'h48, 32'h1);
        rd(8'h54, 32'h1, "R6 masked after mask write");
        chk_irq(1'b1, "R6 irq high");

        // R7 acknowledge
        wr(8'h4C, 32'h1);
        rd(8'h50, 32'h0, "R7 ack clears bit0");
        rd(8'h4C, 32'h0, "R7 ack reads zero");
        chk_irq(1'b0, "R7 irq low after ack");

        // R8 hold
        wr(8'h08, 32'h11);
        pulse_rate(4'b0001);
        rd(8'h04, 32'd3, "R8 hold keeps count");

        // R9 illegal op and disabled source
        wr(8'h08, 32'h13);
        pulse_rate(4'b0001);
        rd(8'h04, 32'd3, "R9 op3 holds");
        rd(8'h08, 32'h13, "R9 ctrl readback op3");
        wr(8'h08, 32'h02);
        pulse_rate(4'b1111);
        pulse_ext();
        rd(8'h04, 32'd3, "R9 source0 never ticks");

        // Timer 1 on external source, divisor 1
        wr(8'h10, 32'd1);
        wr(8'h18, 32'h04);
        rd(8'h14, 32'd1, "R2 timer1 load");
        wr(8'h18, 32'h06);
        pulse_ext();
        rd(8'h14, 32'd1, "R4 timer1 reload divisor1");
        rd(8'h50, 32'h2, "R5 timer1 sets bit1");
        rd(8'h54, 32'h0, "R6 bit1 masked off");
        chk_irq(1'b0, "R6 irq low bit1 masked");
        wr(8'h48, 32'h3);
        rd(8'h54, 32'h2, "R6 masked bit1");
        chk_irq(1'b1, "R6 irq from timer1");
        wr(8'h4C, 32'h1);
        rd(8'h50, 32'h2, "R7 ack other bit keeps bit1");
        wr(8'h4C, 32'h2);
        rd(8'h50, 32'h0, "R7 ack bit1");
        chk_irq(1'b0, "R7 irq low");

        // R10 time counter
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            time_tick = 1'b1;
            @(negedge clk);
            time_tick = 1'b0;
        end
        rd(8'h38, 32'd5, "R10 time count");
        wr(8'h38, 32'hABCD);
        rd(8'h38, 32'd5, "R10 time write ignored");

        // R11 unmapped
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R11 unmapped read");
        rd(8'h00, 32'd3, "R11 div0 untouched");
        rd(8'h10, 32'd1, "R11 div1 untouched");
        rd(8'h48, 32'h3, "R11 mask untouched");

        // R2 divisor write alone
        wr(8'h00, 32'd9);
        rd(8'h04, 32'd3, "R2 div write keeps cnt0");
        rd(8'h00, 32'd9, "R2 div readback");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++)
            @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule